// File: doc/BRIEF.md
# Self-Checking Microprogram Sequencer

This block is the control sequencer of a microprogrammed unit with concurrent error detection. A microprogram counter addresses a 32-word microcode store. Each word holds a control field, a 2-bit next-address selector, a copy of its own address and a check field. The control field of the addressed word drives the datapath directly. The selector picks the next counter value, and two 16-entry dispatch tables map the 4-bit opcode to entry points of the microcode.

Two checks run in every cycle, each against a redundant field of the fetched word. The stored address is compared with the live counter to catch sequencing faults. The check field holds the number of zero bits in the control field, and the checker recounts the zeros to catch corrupted control bits. Each detector drives its own registered error flag. The flag stays set until reset.

Two test inputs support checks of the detectors. One flips the lowest counter bit on the way to the store. The other flips control bit 0 after the fetch.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the counter is loaded with 0 and both error flags are cleared. After that edge, `upc_out` is 0.
- R2: The selector encoding is 0 = go to address 0, 1 = counter plus one, 2 = first dispatch table, 3 = second dispatch table. Words at odd addresses 1..15 and words at addresses 16..31 with address bits [1:0] != 3 select code 1. Words at addresses 16..31 with address bits [1:0] == 3 select code 0.
- R3: The word at address 0 selects code 2. The first dispatch table gives the next address as opcode + 1.
- R4: Words at even addresses 2..14 select code 3. The second dispatch table gives the next address as 16 + opcode.
- R5: `ctl_out` equals the control field of the word at `upc_out`. For address a, this field is {a[4:0], ~a[4:0], a[1:0]}, which is 12 bits wide.
- R6: `seq_err` rises one cycle after a cycle in which the stored address of the fetched word differs from the counter. Driving `inj_upc_flip` high causes such a mismatch. The flag then stays high until reset.
- R7: `code_err` rises one cycle after a cycle in which the zero count of the control field differs from the check field. Driving `inj_ctl_flip` high causes this and also inverts bit 0 of `ctl_out`. The flag then stays high until reset.
- R8: A corrupted control bit leaves `seq_err` low, and a counter fault leaves `code_err` low, because each fault disturbs only one of the two redundant fields.
- R9: A reset applied after a flag has been set clears it, and normal sequencing resumes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode that indexes both dispatch tables |
| inj_upc_flip | input | 1 | Test hook: inverts counter bit 0 at the store address |
| inj_ctl_flip | input | 1 | Test hook: inverts control bit 0 after fetch |
| ctl_out | output | 12 | Control word to the datapath |
| upc_out | output | 5 | Current microprogram counter |
| seq_err | output | 1 | Sticky sequencing-error flag |
| code_err | output | 1 | Sticky control-code-error flag |

## Verification
Opcodes 0 and 15 are driven through both dispatch tables. Opcode 15 sends the first table to address 16 and the second to address 31, so a table built off by one, or an adder that wraps, lands on the wrong word. The wrap from address 31 back to 0 is also exercised, as are long runs that cross the boundary between the two halves of the store. A sequencer that decodes the selector field wrongly loses step with the reference path at once.

Each fault hook is applied for a single cycle. Several later cycles are then checked. This exposes a flag that is not sticky, a flag that rises in the wrong cycle, and a flag that is cross-wired to the other detector. A reset in the middle of a run must clear a set flag.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UPC_W     = 5;
    localparam int OPC_W     = 4;
    localparam int CTL_W     = 2 * UPC_W + 2;
    localparam int CHK_W     = $clog2(CTL_W + 1);
    localparam int ROM_DEPTH = 1 << UPC_W;
    localparam int DSP_DEPTH = 1 << OPC_W;

    typedef enum logic [1:0] {
        SEQ_ZERO = 2'd0,
        SEQ_INC  = 2'd1,
        SEQ_DSP1 = 2'd2,
        SEQ_DSP2 = 2'd3
    } seq_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        seq_e             seq;
        logic [UPC_W-1:0] tag;
        logic [CHK_W-1:0] chk;
    } uword_t;

    function automatic logic [CHK_W-1:0] zero_count(input logic [CTL_W-1:0] v);
        logic [CHK_W-1:0] n;
        n = '0;
        for (int i = 0; i < CTL_W; i++) begin
            if (!v[i]) n = n + 1'b1;
        end
        return n;
    endfunction

    function automatic uword_t build_word(input int unsigned a);
        uword_t           w;
        logic [UPC_W-1:0] ad;
        ad    = UPC_W'(a);
        w.ctl = {ad, ~ad, ad[1:0]};
        w.tag = ad;
        w.chk = zero_count(w.ctl);
        if (ad == '0)
            w.seq = SEQ_DSP1;
        else if (ad < UPC_W'(ROM_DEPTH / 2))
            w.seq = ad[0] ? SEQ_INC : SEQ_DSP2;
        else
            w.seq = (ad[1:0] == 2'b11) ? SEQ_ZERO : SEQ_INC;
        return w;
    endfunction

    function automatic logic [UPC_W-1:0] disp1_entry(input int unsigned op);
        return UPC_W'(op) + UPC_W'(1);
    endfunction

    function automatic logic [UPC_W-1:0] disp2_entry(input int unsigned op);
        return UPC_W'(ROM_DEPTH / 2) + UPC_W'(op);
    endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);
    uword_t rom [ROM_DEPTH];

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
        assign rom[g] = build_word(g);
    end

    assign word = rom[addr];
endmodule

// File: rtl/ucode_next.sv
module ucode_next
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    input  seq_e             seq,
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] nxt
);
    logic [UPC_W-1:0] tbl1 [DSP_DEPTH];
    logic [UPC_W-1:0] tbl2 [DSP_DEPTH];

    for (genvar g = 0; g < DSP_DEPTH; g++) begin : g_dsp
        assign tbl1[g] = disp1_entry(g);
        assign tbl2[g] = disp2_entry(g);
    end

    always_comb begin
        unique case (seq)
            SEQ_ZERO: nxt = '0;
            SEQ_INC:  nxt = upc + UPC_W'(1);
            SEQ_DSP1: nxt = tbl1[opcode];
            SEQ_DSP2: nxt = tbl2[opcode];
            default:  nxt = '0;
        endcase
    end
endmodule

// File: rtl/ucode_check.sv
module ucode_check
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [UPC_W-1:0] upc,
    input  uword_t           word,
    output logic             seq_err,
    output logic             code_err
);
    logic tag_bad;
    logic chk_bad;

    assign tag_bad = (word.tag != upc);
    assign chk_bad = (zero_count(word.ctl) != word.chk);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_err  <= 1'b0;
            code_err <= 1'b0;
        end else begin
            seq_err  <= seq_err  | tag_bad;
            code_err <= code_err | chk_bad;
        end
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             inj_upc_flip,
    input  logic             inj_ctl_flip,
    output logic [CTL_W-1:0] ctl_out,
    output logic [UPC_W-1:0] upc_out,
    output logic             seq_err,
    output logic             code_err
);
    logic [UPC_W-1:0] upc_q;
    logic [UPC_W-1:0] upc_d;
    logic [UPC_W-1:0] rom_addr;
    uword_t           fetched;
    uword_t           checked;

    assign rom_addr = upc_q ^ {{(UPC_W-1){1'b0}}, inj_upc_flip};

    ucode_rom i_rom (
        .addr (rom_addr),
        .word (fetched)
    );

    always_comb begin
        checked        = fetched;
        checked.ctl[0] = fetched.ctl[0] ^ inj_ctl_flip;
    end

    ucode_next i_next (
        .upc    (upc_q),
        .seq    (checked.seq),
        .opcode (opcode),
        .nxt    (upc_d)
    );

    ucode_check i_check (
        .clk      (clk),
        .rst      (rst),
        .upc      (upc_q),
        .word     (checked),
        .seq_err  (seq_err),
        .code_err (code_err)
    );

    always_ff @(posedge clk) begin
        if (rst) upc_q <= '0;
        else     upc_q <= upc_d;
    end

    assign upc_out = upc_q;
    assign ctl_out = checked.ctl;
endmodule

// File: rtl/useq_sva.sv
module useq_sva (
    input logic       clk,
    input logic       rst,
    input logic [3:0] opcode,
    input logic       inj_upc_flip,
    input logic       inj_ctl_flip,
    input logic [4:0] upc_out,
    input logic       seq_err,
    input logic       code_err
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (upc_out == 5'd0 && !seq_err && !code_err));

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_out == 5'd31 && !inj_upc_flip) |=> upc_out == 5'd0);

    // R3
    dispatch_one_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_out == 5'd0 && !inj_upc_flip) |=> upc_out == 5'($past(opcode)) + 5'd1);

    // R6
    seq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    // R6
    seq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> $past(inj_upc_flip));

    // R7
    code_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err);

    // R7
    code_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(code_err) |-> $past(inj_ctl_flip));
endmodule

bind useq_top useq_sva i_sva (
    .clk          (clk),
    .rst          (rst),
    .opcode       (opcode),
    .inj_upc_flip (inj_upc_flip),
    .inj_ctl_flip (inj_ctl_flip),
    .upc_out      (upc_out),
    .seq_err      (seq_err),
    .code_err     (code_err)
);

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;

    typedef struct {
        logic [4:0]  upc;
        logic [11:0] ctl;
        logic        se;
        logic        ce;
        bit          path_ok;
        string       rpath;
        string       rflag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = '0;
    logic        inj_upc_flip = 1'b0;
    logic        inj_ctl_flip = 1'b0;
    logic [11:0] ctl_out;
    logic [4:0]  upc_out;
    logic        seq_err;
    logic        code_err;

    int vectors = 0;
    int miscompares = 0;

    exp_t q[$];

    logic [4:0] m_upc = '0;
    logic       m_se = 1'b0;
    logic       m_ce = 1'b0;
    bit         m_lost = 1'b0;
    string      m_rq = "R1";
    string      m_rf = "R1";

    always #4 clk = ~clk;

    useq_top i_useq_top (
        .clk          (clk),
        .rst          (rst),
        .opcode       (opcode),
        .inj_upc_flip (inj_upc_flip),
        .inj_ctl_flip (inj_ctl_flip),
        .ctl_out      (ctl_out),
        .upc_out      (upc_out),
        .seq_err      (seq_err),
        .code_err     (code_err)
    );

    // R5 control field of address a
    function automatic logic [11:0] exp_ctl(input logic [4:0] a);
        return {a, ~a, a[1:0]};
    endfunction

    task automatic model_advance(input logic [3:0] op);
        int a;
        a = int'(m_upc);
        if (a == 0) begin
            m_upc = 5'(int'(op) + 1);
            m_rq  = "R3";
        end else if (a < 16) begin
            if (a % 2 == 1) begin
                m_upc = 5'(a + 1);
                m_rq  = "R2";
            end else begin
                m_upc = 5'(16 + int'(op));
                m_rq  = "R4";
            end
        end else begin
            m_upc = (a % 4 == 3) ? 5'd0 : 5'(a + 1);
            m_rq  = "R2";
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk); #1;
        rst = 1'b1; inj_upc_flip = 1'b0; inj_ctl_flip = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        m_upc = '0; m_se = 1'b0; m_ce = 1'b0; m_lost = 1'b0;
        m_rq = tag; m_rf = tag;
    endtask

    // caller stands just after a falling edge
    task automatic step(input logic [3:0] op, input logic iu, input logic ic);
        exp_t e;
        opcode = op; inj_upc_flip = iu; inj_ctl_flip = ic;
        e.upc     = m_upc;
        e.ctl     = exp_ctl(m_upc) ^ {11'b0, ic};
        e.se      = m_se;
        e.ce      = m_ce;
        e.path_ok = !m_lost && !iu;
        e.rpath   = m_rq;
        e.rflag   = m_rf;
        q.push_back(e);
        @(posedge clk);
        if (iu) begin m_se = 1'b1; m_lost = 1'b1; m_rf = "R6"; end
        if (ic) begin m_ce = 1'b1; m_rf = "R7"; end
        model_advance(op);
        @(negedge clk); #1;
        inj_upc_flip = 1'b0; inj_ctl_flip = 1'b0;
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk); #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.path_ok) begin
                    vectors++;
                    if (upc_out !== e.upc) begin
                        miscompares++;
                        $display("FAIL %s upc_out got %0d expected %0d", e.rpath, upc_out, e.upc);
                    end
                    vectors++;
                    if (ctl_out !== e.ctl) begin
                        miscompares++;
                        $display("FAIL R5 ctl_out got %h expected %h", ctl_out, e.ctl);
                    end
                end
                vectors++;
                if (seq_err !== e.se) begin
                    miscompares++;
                    $display("FAIL %s R8 seq_err got %b expected %b", e.rflag, seq_err, e.se);
                end
                vectors++;
                if (code_err !== e.ce) begin
                    miscompares++;
                    $display("FAIL %s R8 code_err got %b expected %b", e.rflag, code_err, e.ce);
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        miscompares++;
        $display("FAIL watchdog expired got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [3:0] lfsr;
        lfsr = 4'h9;
        // R1 reset state and start of run
        do_reset("R1");
        // R3 R4 edge opcodes 0 and 15 through both tables
        step(4'd0, 1'b0, 1'b0);
        step(4'd0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(4'd15, 1'b0, 1'b0);
        for (int i = 0; i < 24; i++) step(4'd0, 1'b0, 1'b0);
        // R2 R3 R4 mixed opcode pattern
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
            step(lfsr, 1'b0, 1'b0);
        end
        for (int i = 0; i < 40; i++) step(4'(i), 1'b0, 1'b0);
        // R7 R8 control corruption for one cycle
        m_rf = "R8";
        step(4'd6, 1'b0, 1'b1);
        for (int i = 0; i < 12; i++) step(4'(i + 3), 1'b0, 1'b0);
        // R9 reset clears code_err
        do_reset("R9");
        for (int i = 0; i < 8; i++) step(4'd7, 1'b0, 1'b0);
        // R6 R8 counter fault for one cycle
        step(4'd2, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step(4'd2, 1'b0, 1'b0);
        // both faults together
        do_reset("R9");
        step(4'd4, 1'b0, 1'b0);
        step(4'd4, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step(4'd4, 1'b0, 1'b0);
        // R9 recovery
        do_reset("R9");
        for (int i = 0; i < 30; i++) step(4'(15 - i % 16), 1'b0, 1'b0);
        @(negedge clk); #4;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule